// File: doc/BRIEF.md
# Immediate Operand Execution Unit

This block computes the result of the immediate-form instructions of a 32-bit RISC core. It takes a 6-bit opcode, the value read from the source register, and the 16-bit immediate field of the instruction word. It returns a 32-bit result for write-back, together with a flag that is raised when the opcode is not one of the four the unit serves.

There are four operations. Load-upper places the immediate in the high half of the word and ignores the source register. Add-immediate sign-extends the immediate and adds it to the source. AND-immediate and OR-immediate zero-extend the immediate and combine it with the source bit by bit. The opcode alone decides whether the immediate is zero-extended or sign-extended. The unit has no registers, so a result is valid in the same cycle as the inputs that produce it. A full 32-bit constant takes two steps: a load-upper of the high half, then an OR-immediate of the low half into that value.

Top module: `imm_exec_unit`

## Requirements
- R1: With opcode 0x0F (load-upper), result bits 31:16 equal the immediate and bits 15:0 are zero, whatever the source value.
- R2: With opcode 0x0C (AND-immediate), the result is the source AND the immediate with 16 zero bits prepended, so bits 31:16 are always zero.
- R3: With opcode 0x0D (OR-immediate), the result is the source OR the zero-extended immediate, so bits 31:16 copy the source.
- R4: With opcode 0x08 (add-immediate), the result is the source plus the immediate read as a 16-bit two's complement value, taken modulo 2^32, and no exception or flag is raised on overflow.
- R5: Any opcode other than 0x08, 0x0C, 0x0D and 0x0F drives the result to zero.
- R6: The unsupported flag is 1 exactly for opcodes outside the set 0x08, 0x0C, 0x0D, 0x0F, and 0 for the four members of that set.
- R7: The result follows the inputs within the same cycle, with no clock edge between a change of input and the new result.
- R8: A load-upper of 0x76B5, followed by an OR-immediate of 0x2134 into that result, yields 0x76B52134.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opc_i | input | 6 | Operation code of the instruction |
| rs_val_i | input | 32 | Value read from the source register |
| imm_i | input | 16 | Immediate field of the instruction |
| result_o | output | 32 | Value to write back |
| unsupported_o | output | 1 | High when the opcode is not served by this unit |

## Verification
The immediate-extension step and the operation selection act together in every cycle, and the opcode alone sets both. A wrong extension therefore shows only when immediate bit 15 is set. The bench drives immediates with bit 15 set and with it clear under all four opcodes, applies carry-heavy sources to add-immediate, and sweeps every one of the 64 opcode values. Each output is compared in the same cycle with a behavioural model of the four operations. The model also catches an unsupported opcode that leaks a result, and a load-upper that lets the source through.

// File: rtl/imm_exec_pkg.sv
// Package: shared widths, opcode values and the internal operation kind
// for the immediate execution unit.
// Assumes: 6-bit opcodes, as used by the core's instruction decoder.
package imm_exec_pkg;
    localparam int OPC_W = 6;

    localparam logic [OPC_W-1:0] OPC_ADDI = 6'h08;
    localparam logic [OPC_W-1:0] OPC_ANDI = 6'h0C;
    localparam logic [OPC_W-1:0] OPC_ORI  = 6'h0D;
    localparam logic [OPC_W-1:0] OPC_LUI  = 6'h0F;

    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_UPPER,
        KIND_ADD,
        KIND_AND,
        KIND_OR
    } op_kind_e;

    typedef struct packed {
        op_kind_e kind;
        logic     sign_ext;
        logic     bad_opc;
    } op_ctrl_t;
endpackage

// File: rtl/imm_decode.sv
// Module: imm_decode
// Maps the opcode to an operation kind, an extension mode and an
// unsupported flag. Purely combinational.
// Assumes: opcode values come from imm_exec_pkg.
module imm_decode
    import imm_exec_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    output op_ctrl_t         ctrl
);
    // Select the operation and the extension mode for the opcode.
    always_comb begin
        ctrl.kind     = KIND_NONE;
        ctrl.sign_ext = 1'b0;
        ctrl.bad_opc  = 1'b0;
        unique case (opc)
            OPC_LUI:  ctrl.kind = KIND_UPPER;
            OPC_ADDI: begin
                ctrl.kind     = KIND_ADD;
                ctrl.sign_ext = 1'b1;
            end
            OPC_ANDI: ctrl.kind = KIND_AND;
            OPC_ORI:  ctrl.kind = KIND_OR;
            default:  ctrl.bad_opc = 1'b1;
        endcase
    end
endmodule

// File: rtl/imm_extend.sv
// Module: imm_extend
// Widens the immediate to the data width. Zero-fills the upper bits, or
// copies the immediate's top bit into them when sign_ext is set.
// Assumes: IMM_W <= DATA_W.
module imm_extend #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [IMM_W-1:0]  imm,
    input  logic              sign_ext,
    output logic [DATA_W-1:0] ext
);
    localparam int PAD_W = DATA_W - IMM_W;

    generate
        if (PAD_W > 0) begin : g_pad
            logic fill_bit;
            // Choose the bit that fills the upper part of the word.
            always_comb fill_bit = sign_ext & imm[IMM_W-1];
            // Put the fill bits on top of the immediate.
            always_comb ext = {{PAD_W{fill_bit}}, imm};
        end else begin : g_same
            logic unused_sel;
            // Widths match: nothing to fill.
            always_comb unused_sel = sign_ext;
            always_comb ext = imm[DATA_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/imm_upper.sv
// Module: imm_upper
// Places the immediate at the top of the data word with zeros below it.
// Assumes: IMM_W <= DATA_W.
module imm_upper #(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [IMM_W-1:0]  imm,
    output logic [DATA_W-1:0] word
);
    localparam int LOW_W = DATA_W - IMM_W;

    generate
        if (LOW_W > 0) begin : g_shift
            // Immediate on top, zeros underneath.
            always_comb word = {imm, {LOW_W{1'b0}}};
        end else begin : g_full
            always_comb word = imm[DATA_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/imm_exec_unit.sv
// Module: imm_exec_unit (top)
// Runs load-upper, add-immediate, AND-immediate and OR-immediate in a
// single combinational step. Unsupported opcodes give a zero result and
// raise unsupported_o. The add wraps modulo 2^DATA_W and does not trap.
// Assumes: the caller handles register access and overflow traps.
module imm_exec_unit
    import imm_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input  logic [OPC_W-1:0]  opc_i,
    input  logic [DATA_W-1:0] rs_val_i,
    input  logic [IMM_W-1:0]  imm_i,
    output logic [DATA_W-1:0] result_o,
    output logic              unsupported_o
);
    op_ctrl_t          ctrl;
    logic [DATA_W-1:0] imm_ext;
    logic [DATA_W-1:0] upper_val;
    logic [DATA_W-1:0] sum_val;
    logic [DATA_W-1:0] and_val;
    logic [DATA_W-1:0] or_val;

    imm_decode u_dec (
        .opc  (opc_i),
        .ctrl (ctrl)
    );

    imm_extend #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
        .imm      (imm_i),
        .sign_ext (ctrl.sign_ext),
        .ext      (imm_ext)
    );

    imm_upper #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_up (
        .imm  (imm_i),
        .word (upper_val)
    );

    // Add the widened immediate and drop the carry out.
    always_comb sum_val = rs_val_i + imm_ext;

    // Bitwise AND and OR with the widened immediate.
    always_comb begin
        and_val = rs_val_i & imm_ext;
        or_val  = rs_val_i | imm_ext;
    end

    // Choose the result for the decoded operation.
    always_comb begin
        unique case (ctrl.kind)
            KIND_UPPER: result_o = upper_val;
            KIND_ADD:   result_o = sum_val;
            KIND_AND:   result_o = and_val;
            KIND_OR:    result_o = or_val;
            default:    result_o = '0;
        endcase
    end

    // Report opcodes this unit does not serve.
    always_comb unsupported_o = ctrl.bad_opc;
endmodule

// File: rtl/imm_exec_unit_chk.sv
// Module: imm_exec_unit_chk
// Port-level checks on imm_exec_unit, attached with bind. Checks are
// skipped while any input is unknown.
module imm_exec_unit_chk
    import imm_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int IMM_W  = 16
) (
    input logic [OPC_W-1:0]  opc_i,
    input logic [DATA_W-1:0] rs_val_i,
    input logic [IMM_W-1:0]  imm_i,
    input logic [DATA_W-1:0] result_o,
    input logic              unsupported_o
);
    localparam int PAD_W = DATA_W - IMM_W;

    logic known;
    logic in_set;
    // Inputs are fully defined.
    always_comb known = !$isunknown({opc_i, rs_val_i, imm_i});
    // Opcode is one of the four served.
    always_comb in_set = (opc_i == 6'h08) || (opc_i == 6'h0C) ||
                         (opc_i == 6'h0D) || (opc_i == 6'h0F);

    // Check the outputs against the opcode's rule.
    always_comb begin
        if (known) begin
            // R1
            lui_shape_chk: assert (opc_i != 6'h0F ||
                (result_o[DATA_W-1:PAD_W] == imm_i && result_o[PAD_W-1:0] == '0))
                else $error("load-upper result malformed");
            // R2
            andi_top_zero_chk: assert (opc_i != 6'h0C || result_o[DATA_W-1:IMM_W] == '0)
                else $error("AND-immediate set upper bits");
            // R3
            ori_low_chk: assert (opc_i != 6'h0D ||
                (result_o[IMM_W-1:0] == (rs_val_i[IMM_W-1:0] | imm_i) &&
                 result_o[DATA_W-1:IMM_W] == rs_val_i[DATA_W-1:IMM_W]))
                else $error("OR-immediate result wrong");
            // R5
            bad_zero_chk: assert (in_set || result_o == '0)
                else $error("unsupported opcode gave nonzero result");
            // R6
            flag_match_chk: assert (unsupported_o == !in_set)
                else $error("unsupported flag mismatch");
        end
    end
endmodule

bind imm_exec_unit imm_exec_unit_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_chk (
    .opc_i         (opc_i),
    .rs_val_i      (rs_val_i),
    .imm_i         (imm_i),
    .result_o      (result_o),
    .unsupported_o (unsupported_o)
);

// File: tb/imm_exec_unit_test.sv
// Bench: compares imm_exec_unit with a behavioural model once per clock.
module imm_exec_unit_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  opc = 6'h00;
    logic [31:0] rs_val = 32'h0;
    logic [15:0] imm = 16'h0;
    logic [31:0] result;
    logic        unsup;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #5 clk = ~clk;

    imm_exec_unit uut (
        .opc_i         (opc),
        .rs_val_i      (rs_val),
        .imm_i         (imm),
        .result_o      (result),
        .unsupported_o (unsup)
    );

    function automatic longint unsigned model_res(input int o, input longint unsigned s,
                                                  input int i);
        longint signed si;
        si = (i >= 32768) ? i - 65536 : i;
        case (o)
            15: return (longint'(i) * 65536);
            8:  return (s + longint'(si)) % 64'h1_0000_0000;
            12: return s & longint'(i);
            13: return s | longint'(i);
            default: return 0;
        endcase
    endfunction

    function automatic bit model_bad(input int o);
        return !(o == 8 || o == 12 || o == 13 || o == 15);
    endfunction

    task automatic check(input string req, input logic [31:0] exp_r, input logic exp_u);
        checks++;
        if (result !== exp_r || unsup !== exp_u) begin
            fails++;
            $display("FAIL %s opc=%h rs=%h imm=%h result=%h exp=%h flag=%b exp=%b",
                     req, opc, rs_val, imm, result, exp_r, unsup, exp_u);
        end
    endtask

    // Drive after the rising edge, compare at the falling edge.
    task automatic apply(input string req, input logic [5:0] o, input logic [31:0] s,
                         input logic [15:0] i);
        @(posedge clk);
        #1;
        opc = o; rs_val = s; imm = i;
        @(negedge clk);
        check(req, 32'(model_res(int'(o), longint'(s), int'(i))), model_bad(int'(o)));
    endtask

    initial begin : stim
        logic [31:0] lfsr;
        logic [31:0] hi;
        repeat (2) @(posedge clk);
        @(negedge clk);
        check("R5 reset", 32'h0, 1'b1);
        rst_n = 1'b1;

        apply("R1", 6'h0F, 32'hFFFF_FFFF, 16'h7F40);
        apply("R1", 6'h0F, 32'h1234_5678, 16'h8001);
        apply("R2", 6'h0C, 32'h7F40_0777, 16'h5555);
        apply("R2", 6'h0C, 32'hFFFF_FFFF, 16'hFFFF);
        apply("R3", 6'h0D, 32'h7F40_0777, 16'h5555);
        apply("R3", 6'h0D, 32'h0000_0000, 16'h8000);
        apply("R4", 6'h08, 32'h7F40_0000, 16'h0777);
        apply("R4", 6'h08, 32'h0000_0005, 16'hFFFF);
        apply("R4", 6'h08, 32'h0000_0000, 16'h8000);
        apply("R4", 6'h08, 32'hFFFF_FFFF, 16'h0001);
        apply("R4", 6'h08, 32'h7FFF_FFFF, 16'h0001);

        // R7: change inputs within one low phase, no edge between.
        @(posedge clk); #1;
        opc = 6'h0D; rs_val = 32'h0000_00F0; imm = 16'h000F;
        #1;
        check("R7", 32'h0000_00FF, 1'b0);
        imm = 16'h0F00;
        #1;
        check("R7", 32'h0000_0FF0, 1'b0);

        // R8: build a 32-bit constant in two steps.
        apply("R8", 6'h0F, 32'hDEAD_BEEF, 16'h76B5);
        hi = result;
        apply("R8", 6'h0D, hi, 16'h2134);
        check("R8 const", 32'h76B5_2134, 1'b0);

        // R5 R6: sweep every opcode.
        for (int k = 0; k < 64; k++)
            apply("R5 R6", 6'(k), 32'hA5A5_5A5A, 16'hC3C3);

        // Pseudo-random mix over the four opcodes and a few bad ones.
        lfsr = 32'h1BAD_5EED;
        for (int n = 0; n < 200; n++) begin
            logic [5:0] pick;
            lfsr = lfsr * 32'd1664525 + 32'd1013904223;
            case (lfsr[31:29])
                3'd0, 3'd1: pick = 6'h08;
                3'd2:       pick = 6'h0C;
                3'd3:       pick = 6'h0D;
                3'd4:       pick = 6'h0F;
                default:    pick = lfsr[5:0];
            endcase
            apply("R1 R2 R3 R4 R5", pick, lfsr ^ {lfsr[15:0], lfsr[31:16]}, lfsr[27:12]);
        end

        if (!done) begin
            done = 1;
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule